// File: doc/BRIEF.md
# E1 Timeslot Substituter with Idle Fill and Loopback

This block sits in the transmit path of an E1 framer, between the serial data from the backplane and the serial stream toward the line. It counts bit and timeslot position inside the 256-bit frame, realigning whenever a frame sync pulse arrives. A 32-bit select mask holds one bit for each timeslot. A cleared bit lets the backplane data through unchanged. A set bit replaces the slot.

What goes into a replaced slot depends on a single mode bit. With the mode bit clear, every selected slot carries one shared 8-bit fill code. With the mode bit set, every selected slot carries the matching timeslot of the receive-side framer output, which gives per-channel loopback. Both streams share one clock and one frame sync.

A plain write port loads the mask bytes, the fill code and the mode bit. New settings are picked up only where a timeslot begins, so no slot is ever half replaced. The serial output is registered.

Top module: `e1_slot_substituter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `line_data` is 0. After reset the mask is all zeros and the mode bit is 0.
- R2: `line_data` in the cycle after an input bit equals the substituted value of that bit, so latency is exactly one clock.
- R3: A timeslot whose select bit is 0 carries `bp_data` unchanged, whatever the mode.
- R4: With mode 0, a selected timeslot carries the fill code most-significant bit first. Bit k of the slot (k = 0 is the first bit after the slot boundary) is fill-code bit 7-k.
- R5: With mode 1, a selected timeslot carries `rx_data` of the same cycle.
- R6: The mask is written through four byte addresses, 0x26 to 0x29. Address 0x26+n bit j selects timeslot 8n+j, so timeslot 0 is bit 0 of 0x26 and timeslot 31 is bit 7 of 0x29. The fill code is written at 0x2A. The mode bit is bit 0 of 0x2B.
- R7: `fsync` high marks bit 0 of timeslot 0 for the bit presented in that cycle. Without `fsync`, position advances one bit per clock and wraps from bit 7 of slot 31 to bit 0 of slot 0.
- R8: A write takes effect from the first timeslot that begins after the write's clock edge. The remaining bits of a slot already in progress keep the old mask, mode and fill code.
- R9: Writes to any address outside 0x26 to 0x2B change nothing on `line_data`.
- R10: Any subset of timeslots can be selected, from none to all 32, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both serial streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, high on bit 0 of timeslot 0 |
| bp_data | input | 1 | Backplane serial data |
| rx_data | input | 1 | Receive-side framer serial data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| line_data | output | 1 | Substituted serial output toward the line |

## Verification
The bench builds the block with its default values: 32 slots of 8 bits, 8-bit addresses and the mask base at 0x26. At these values a full 256-bit frame, the wrap from slot 31 to slot 0, and both edge mask bytes are reached in a few hundred cycles. That leaves room for dozens of random frames in which writes land at random bit positions. These frames also include stray frame sync pulses and writes to unused addresses, next to directed cases for the slot boundary, the all-selected mask and the empty mask.

// File: rtl/e1sub_pkg.sv
package e1sub_pkg;

   localparam int CODE_W = 8;
   localparam int REG_W  = 8;

   typedef struct packed {
      logic              sel;
      logic              loop;
      logic [CODE_W-1:0] code;
   } slot_cfg_t;

endpackage

// File: rtl/e1sub_position.sv
module e1sub_position #(
   parameter int SLOTS     = 32,
   parameter int SLOT_BITS = 8,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int BIT_W    = $clog2(SLOT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [BIT_W-1:0]  cur_bit,
   output logic              slot_start
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;

   always_comb begin
      cur_slot   = fsync ? '0 : slot_q;
      cur_bit    = fsync ? '0 : bit_q;
      slot_start = (cur_bit == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else if (cur_bit == LAST_BIT) begin
         bit_q  <= '0;
         slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      end else begin
         bit_q  <= cur_bit + 1'b1;
         slot_q <= cur_slot;
      end
   end

endmodule

// File: rtl/e1sub_cfg.sv
module e1sub_cfg
   import e1sub_pkg::*;
#(
   parameter int                SLOTS      = 32,
   parameter int                ADDR_W     = 8,
   parameter int                MASK_BASE  = 'h26,
   parameter int                CODE_ADDR  = 'h2A,
   parameter int                MODE_ADDR  = 'h2B,
   parameter logic [CODE_W-1:0] CODE_RESET = 8'hD5,
   localparam int               MASK_REGS  = SLOTS / REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [SLOTS-1:0]  mask_stage,
   output logic [CODE_W-1:0] code_stage,
   output logic              loop_stage
);

   logic unused_bits;
   assign unused_bits = ^wr_data[REG_W-1:1];

   for (genvar g = 0; g < MASK_REGS; g++) begin : g_mask_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_stage[g*REG_W +: REG_W] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(MASK_BASE + g))
            mask_stage[g*REG_W +: REG_W] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_stage <= CODE_RESET;
         loop_stage <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(CODE_ADDR)) code_stage <= wr_data[CODE_W-1:0];
         if (wr_addr == ADDR_W'(MODE_ADDR)) loop_stage <= wr_data[0];
      end
   end

endmodule

// File: rtl/e1sub_slot_hold.sv
module e1sub_slot_hold
   import e1sub_pkg::*;
#(
   parameter int SLOTS   = 32,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_start,
   input  logic [SLOT_W-1:0] cur_slot,
   input  logic [SLOTS-1:0]  mask_stage,
   input  logic [CODE_W-1:0] code_stage,
   input  logic              loop_stage,
   output slot_cfg_t         slot_eff
);

   slot_cfg_t fresh;
   slot_cfg_t held_q;

   always_comb begin
      fresh.sel  = mask_stage[cur_slot];
      fresh.loop = loop_stage;
      fresh.code = code_stage;
      slot_eff   = slot_start ? fresh : held_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held_q <= '0;
      else if (slot_start) held_q <= fresh;
   end

endmodule

// File: rtl/e1sub_out.sv
module e1sub_out
   import e1sub_pkg::*;
#(
   parameter int SLOT_BITS = 8,
   localparam int BIT_W    = $clog2(SLOT_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  slot_cfg_t        slot_eff,
   input  logic [BIT_W-1:0] cur_bit,
   input  logic             bp_data,
   input  logic             rx_data,
   output logic             line_data
);

   logic [BIT_W-1:0] code_idx;
   logic             nxt;

   always_comb begin
      code_idx = BIT_W'(SLOT_BITS - 1) - cur_bit;
      if (!slot_eff.sel)      nxt = bp_data;
      else if (slot_eff.loop) nxt = rx_data;
      else                    nxt = slot_eff.code[code_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_data <= 1'b0;
      else        line_data <= nxt;
   end

endmodule

// File: rtl/e1_slot_substituter.sv
module e1_slot_substituter
   import e1sub_pkg::*;
#(
   parameter int                SLOTS      = 32,
   parameter int                SLOT_BITS  = 8,
   parameter int                ADDR_W     = 8,
   parameter int                MASK_BASE  = 'h26,
   parameter int                CODE_ADDR  = 'h2A,
   parameter int                MODE_ADDR  = 'h2B,
   parameter logic [CODE_W-1:0] CODE_RESET = 8'hD5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   input  logic              bp_data,
   input  logic              rx_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic              line_data
);

   localparam int SLOT_W    = $clog2(SLOTS);
   localparam int BIT_W     = $clog2(SLOT_BITS);
   localparam int MASK_REGS = SLOTS / REG_W;

   if (SLOTS % REG_W != 0 || SLOTS < REG_W) begin : g_bad_slots
      $error("SLOTS must be a nonzero multiple of the register width");
   end
   if (SLOT_BITS != CODE_W) begin : g_bad_bits
      $error("SLOT_BITS must equal the fill code width");
   end
   if (CODE_ADDR >= MASK_BASE && CODE_ADDR < MASK_BASE + MASK_REGS) begin : g_bad_code
      $error("fill code address overlaps the mask bytes");
   end
   if (MODE_ADDR >= MASK_BASE && MODE_ADDR < MASK_BASE + MASK_REGS) begin : g_bad_mode
      $error("mode address overlaps the mask bytes");
   end
   if (MASK_BASE + MASK_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("mask bytes do not fit in the address space");
   end

   logic [SLOT_W-1:0] cur_slot;
   logic [BIT_W-1:0]  cur_bit;
   logic              slot_start;
   logic [SLOTS-1:0]  mask_stage;
   logic [CODE_W-1:0] code_stage;
   logic              loop_stage;
   slot_cfg_t         slot_eff;

   e1sub_position #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_pos (
      .clk(clk), .rst_n(rst_n), .fsync(fsync),
      .cur_slot(cur_slot), .cur_bit(cur_bit), .slot_start(slot_start)
   );

   e1sub_cfg #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE),
      .CODE_ADDR(CODE_ADDR), .MODE_ADDR(MODE_ADDR), .CODE_RESET(CODE_RESET)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mask_stage(mask_stage), .code_stage(code_stage), .loop_stage(loop_stage)
   );

   e1sub_slot_hold #(.SLOTS(SLOTS)) u_hold (
      .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .cur_slot(cur_slot),
      .mask_stage(mask_stage), .code_stage(code_stage), .loop_stage(loop_stage),
      .slot_eff(slot_eff)
   );

   e1sub_out #(.SLOT_BITS(SLOT_BITS)) u_out (
      .clk(clk), .rst_n(rst_n), .slot_eff(slot_eff), .cur_bit(cur_bit),
      .bp_data(bp_data), .rx_data(rx_data), .line_data(line_data)
   );

endmodule

// File: rtl/e1sub_checker.sv
module e1sub_checker
   import e1sub_pkg::*;
#(
   parameter int SLOTS     = 32,
   parameter int SLOT_BITS = 8,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int BIT_W    = $clog2(SLOT_BITS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bp_data,
   input logic              rx_data,
   input logic              line_data,
   input logic [SLOT_W-1:0] cur_slot,
   input logic [BIT_W-1:0]  cur_bit,
   input slot_cfg_t         slot_eff
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

   p_reset_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (line_data == 1'b0));

   p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_eff.sel |=> (line_data == $past(bp_data)));

   p_fill_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_eff.sel && !slot_eff.loop) |=>
         (line_data == $past(slot_eff.code[LAST_BIT - cur_bit])));

   p_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_eff.sel && slot_eff.loop) |=> (line_data == $past(rx_data)));

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot == LAST_SLOT && cur_bit == LAST_BIT) |=>
         (cur_slot == '0 && cur_bit == '0));

   p_slot_whole_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_bit != '0) |-> $stable(slot_eff));

endmodule

bind e1_slot_substituter e1sub_checker #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bp_data(bp_data), .rx_data(rx_data),
   .line_data(line_data), .cur_slot(cur_slot), .cur_bit(cur_bit), .slot_eff(slot_eff)
);

// File: tb/e1_slot_substituter_bench.sv
module e1_slot_substituter_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fsync;
   logic       bp_data;
   logic       rx_data;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic       line_data;

   always #2 clk = ~clk;

   e1_slot_substituter u_e1_slot_substituter (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .bp_data(bp_data), .rx_data(rx_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .line_data(line_data)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // model state, built from the requirements
   logic [31:0] m_mask;
   logic [7:0]  m_code;
   logic        m_loop;
   logic        h_sel, h_loop;
   logic [7:0]  h_code;
   int          m_pos;
   int          bp_force = -1;
   string       cur_tag = "";
   int          zero_cnt;
   int          zero_bad;

   task automatic check(input bit ok, input string tag, input logic act, input logic exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: line_data actual=%0b expected=%0b (pos %0d)", tag, act, exp, m_pos);
      end
   endtask

   function automatic logic fill_bit(input logic [7:0] code, input int bt);
      return code[7 - bt];
   endfunction

   task automatic cyc(input bit fs, input bit we, input logic [7:0] a, input logic [7:0] d);
      logic  bp, rx, exp;
      int    pos, sl, bt;
      string tag;
      bp = (bp_force >= 0) ? bp_force[0] : logic'($urandom % 2);
      rx = logic'($urandom % 2);
      fsync = fs; bp_data = bp; rx_data = rx;
      wr_en = we; wr_addr = a; wr_data = d;
      pos = fs ? 0 : m_pos;
      sl  = pos / 8;
      bt  = pos % 8;
      if (bt == 0) begin
         h_sel  = m_mask[sl];
         h_loop = m_loop;
         h_code = m_code;
      end
      if (!h_sel)     begin exp = bp; tag = "R3"; end
      else if (h_loop) begin exp = rx; tag = "R5"; end
      else            begin exp = fill_bit(h_code, bt); tag = "R4"; end
      if (cur_tag != "") tag = cur_tag;
      @(posedge clk);
      if (we) begin
         case (a)
            8'h26: m_mask[7:0]   = d;
            8'h27: m_mask[15:8]  = d;
            8'h28: m_mask[23:16] = d;
            8'h29: m_mask[31:24] = d;
            8'h2A: m_code        = d;
            8'h2B: m_loop        = d[0];
            default: ;
         endcase
      end
      m_pos = (pos + 1) % 256;
      @(negedge clk);
      check(line_data === exp, tag, line_data, exp);
      if (line_data === 1'b0) begin
         zero_cnt++;
         if (sl != 31) zero_bad++;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cyc(1'b0, 1'b1, a, d);
   endtask

   task automatic idle_to_frame_end();
      while (m_pos != 0) cyc(1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; fsync = 1'b0; bp_data = 1'b0; rx_data = 1'b0;
      wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
      m_mask = '0; m_code = 8'hD5; m_loop = 1'b0;
      h_sel = 1'b0; h_loop = 1'b0; h_code = '0; m_pos = 0;

      // R1: output low during reset
      for (int i = 0; i < 5; i++) begin
         bp_data = 1'b1;
         @(negedge clk);
         check(line_data === 1'b0, "R1", line_data, 1'b0);
      end
      rst_n = 1'b1;

      // R1, R2: passthrough from reset defaults, one clock latency
      cur_tag = "R2";
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
      run(255);

      // R6: only slot 31 selected, fill 0x00, backplane all ones
      cur_tag = "";
      wr(8'h29, 8'h80); wr(8'h2A, 8'h00); wr(8'h2B, 8'h00);
      idle_to_frame_end();
      bp_force = 1;
      cur_tag  = "R6";
      zero_cnt = 0; zero_bad = 0;
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
      run(255);
      checks++;
      if (zero_cnt != 8 || zero_bad != 0) begin
         errors++;
         $display("FAIL R6: fill bits actual=%0d (outside slot 31: %0d) expected=8 (0)", zero_cnt, zero_bad);
      end
      bp_force = -1;

      // R4: fill code bit order in slot 0
      cur_tag = "R4";
      wr(8'h29, 8'h00); wr(8'h26, 8'h01); wr(8'h2A, 8'hB2);
      idle_to_frame_end();
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
      run(15);
      idle_to_frame_end();

      // R8: write in the middle of slot 5 (bit 3)
      cur_tag = "R8";
      wr(8'h26, 8'h00);
      idle_to_frame_end();
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
      run(42);
      wr(8'h26, 8'h60);       // selects slots 5 and 6
      run(20);
      wr(8'h2B, 8'h01);       // mode flip in slot 8, bit 0 was already past
      run(12);
      idle_to_frame_end();

      // R9: writes to unused addresses leave output as passthrough
      cur_tag = "";
      wr(8'h26, 8'h00); wr(8'h2B, 8'h00);
      wr(8'h25, 8'hFF); wr(8'h2C, 8'hFF); wr(8'h30, 8'hFF); wr(8'hA6, 8'hFF);
      idle_to_frame_end();
      cur_tag = "R9";
      run(256);

      // R10: all slots selected in loopback mode, then fill mode, then none
      cur_tag = "";
      wr(8'h26, 8'hFF); wr(8'h27, 8'hFF); wr(8'h28, 8'hFF); wr(8'h29, 8'hFF);
      wr(8'h2B, 8'h01);
      idle_to_frame_end();
      cur_tag = "R10";
      run(256);
      wr(8'h2B, 8'h00); wr(8'h2A, 8'h3C);
      idle_to_frame_end();
      run(256);
      wr(8'h26, 8'h00); wr(8'h27, 8'h00); wr(8'h28, 8'h00); wr(8'h29, 8'h00);
      idle_to_frame_end();
      run(256);

      // R7: stray sync mid-frame, then free wrap without sync
      cur_tag = "R7";
      wr(8'h29, 8'hC3); wr(8'h26, 8'h5A); wr(8'h2A, 8'h96);
      run(97);
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
      run(600);

      // random frames
      cur_tag = "";
      for (int f = 0; f < 80; f++) begin
         for (int i = 0; i < 256; i++) begin
            bit         fs, we;
            logic [7:0] a, d;
            fs = (m_pos == 0 && ($urandom % 4) != 0) || (($urandom % 500) == 0);
            we = (($urandom % 40) == 0);
            a  = 8'h26 + 8'($urandom % 10);
            d  = 8'($urandom);
            cyc(fs, we, a, d);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule